// File: doc/BRIEF.md
# Slow Infrared Baud Rate Generator

This block derives the two timing strobes of the slow asynchronous infrared mode from a fixed reference clock: a 16x oversampling tick and a bit-rate tick. A constant prescaler first reduces the reference rate. A reloadable divider, programmed through a 6-bit baud count, then produces the oversampling tick. Every sixteenth oversampling tick is also a bit tick. With the default parameters, a 48 MHz reference and a count of 11 give 9600 bit/s. The general relation is rate = f_ref / PRESCALE / (count + 1) / 16.

The block also watches a receive-activity input. It raises a one-cycle timeout pulse when the line stays quiet for a selectable number of bit periods. When the timeout fires, the baud count goes back to its 9600 bit/s default, so that the receiver can resynchronise at the base rate. Software programs the block through a small write port that selects one of two registers. Register 0 holds the baud count. Register 1 holds the idle-interval selector.

Top module: `sir_baud_gen`

## Requirements
- R1: `tick16` is a one-cycle pulse. Consecutive pulses are exactly PRESCALE*(count+1) clock cycles apart, where count is the stored baud count.
- R2: A write with `wrAddr`=0 stores `wrData[5:0]` as the baud count. The other bits of `wrData` have no effect on the tick rate.
- R3: After reset, all three outputs are low, the baud count is DEFAULT_COUNT (11, which is 9600 bit/s at 48 MHz with PRESCALE 26), and the timeout is off.
- R4: A new baud count takes effect only after the oversampling interval in progress has run to its full old length. No shortened interval occurs.
- R5: `tickBit` pulses on every sixteenth `tick16` pulse, in the same cycle as that pulse. It is therefore OVERSAMPLE*PRESCALE*(count+1) cycles apart.
- R6: A write with `wrAddr`=1 stores `wrData[9:8]` as the idle selector s. For s in 0..2, `rxTimeout` pulses together with the bit tick on which the number of bit ticks seen while `rxActive` is low reaches TO_BASE<<s. Counting then starts again.
- R7: Selector value 3 disables the timeout. `rxTimeout` stays low however long the line is idle.
- R8: A write with `wrAddr`=1 while `slowMode` is low stores selector 0, whatever the value of `wrData[9:8]`.
- R9: Any cycle with `rxActive` high clears the idle count. A `rxTimeout` pulse never follows a cycle in which `rxActive` was high.
- R10: When `rxTimeout` pulses, the baud count is set back to DEFAULT_COUNT, and this takes priority over a write in the same cycle. The following oversampling intervals use the default length once the interval in progress ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| slowMode | input | 1 | High while the link runs in the slow asynchronous mode |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | Register select: 0 = baud count, 1 = idle selector |
| wrData | input | 16 | Write data |
| rxActive | input | 1 | High while receive activity is seen on the line |
| tick16 | output | 1 | 16x oversampling tick |
| tickBit | output | 1 | Bit-rate tick |
| rxTimeout | output | 1 | One-cycle receive-idle timeout pulse |

## Verification
The bench builds the block with PRESCALE=4 and TO_BASE=2, and keeps DEFAULT_COUNT=11 and OVERSAMPLE=16. With these values, one default-rate oversampling interval is 48 cycles and a bit period at count 0 is 64 cycles. This lets the bench cover, in a few thousand cycles, all three legal idle intervals, the disabled setting, the return to the default count, and rate changes made in the middle of an interval.

// File: rtl/sbg_pkg.sv
package sbg_pkg;
  localparam int CNT_W   = 6;   // baud count field width
  localparam int SEL_W   = 2;   // idle selector width
  localparam int DATA_W  = 16;  // write port width
  localparam int SEL_LSB = 8;   // selector position in register 1

  // Strobes and settings handed from control to datapath
  typedef struct packed {
    logic [CNT_W-1:0] divisor;
    logic [SEL_W-1:0] toSel;
  } sbgCtl_t;
endpackage

// File: rtl/sbg_ctrl.sv
module sbg_ctrl
  import sbg_pkg::*;
#(
  parameter int DEFAULT_COUNT = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowMode,
  input  logic              wrEn,
  input  logic              wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              toHit,
  output sbgCtl_t           ctl
);
  localparam logic ADDR_COUNT = 1'b0;
  localparam logic ADDR_CFG   = 1'b1;
  localparam logic [SEL_W-1:0] SEL_OFF = '1;

  logic [CNT_W-1:0] countReg;
  logic [SEL_W-1:0] selReg;
  logic             unusedData;

  assign unusedData = ^wrData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countReg <= CNT_W'(DEFAULT_COUNT);
      selReg   <= SEL_OFF;
    end else begin
      // A timeout restores the base rate and wins over a same-cycle write
      if (toHit)
        countReg <= CNT_W'(DEFAULT_COUNT);
      else if (wrEn && wrAddr == ADDR_COUNT)
        countReg <= wrData[CNT_W-1:0];
      if (wrEn && wrAddr == ADDR_CFG)
        selReg <= slowMode ? wrData[SEL_LSB +: SEL_W] : '0;
    end
  end

  assign ctl = '{divisor: countReg, toSel: selReg};
endmodule

// File: rtl/sbg_datapath.sv
module sbg_datapath
  import sbg_pkg::*;
#(
  parameter int PRESCALE   = 26,
  parameter int OVERSAMPLE = 16,
  parameter int TO_BASE    = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  sbgCtl_t ctl,
  input  logic    rxActive,
  output logic    toHit,
  output logic    tick16,
  output logic    tickBit,
  output logic    rxTimeout
);
  localparam int PRE_W  = $clog2(PRESCALE);
  localparam int OS_W   = $clog2(OVERSAMPLE);
  localparam int NSEL   = 3;
  localparam int TO_MAX = TO_BASE << (NSEL - 1);
  localparam int TO_W   = $clog2(TO_MAX + 1);

  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] divCnt;
  logic [OS_W-1:0]  osCnt;
  logic [TO_W-1:0]  idleCnt;
  logic [TO_W-1:0]  limTab [NSEL];
  logic [TO_W-1:0]  curLimit;
  logic             preTick, osEvent, bitEvent, toEnable, atLimit;

  // Idle-interval ladder: TO_BASE doubled per selector step
  for (genvar g = 0; g < NSEL; g++) begin : gLim
    assign limTab[g] = TO_W'(TO_BASE << g);
  end

  always_comb begin
    curLimit = limTab[0];
    case (ctl.toSel)
      2'd1:    curLimit = limTab[1];
      2'd2:    curLimit = limTab[2];
      default: curLimit = limTab[0];
    endcase
  end

  assign toEnable = (ctl.toSel != 2'd3);
  assign preTick  = (preCnt == PRE_W'(PRESCALE - 1));
  assign osEvent  = preTick && (divCnt == '0);
  assign bitEvent = osEvent && (osCnt == OS_W'(OVERSAMPLE - 1));
  assign atLimit  = (idleCnt >= curLimit - 1'b1);
  assign toHit    = !rxActive && toEnable && bitEvent && atLimit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt    <= '0;
      divCnt    <= '0;
      osCnt     <= '0;
      idleCnt   <= '0;
      tick16    <= 1'b0;
      tickBit   <= 1'b0;
      rxTimeout <= 1'b0;
    end else begin
      preCnt <= preTick ? '0 : preCnt + 1'b1;
      // Divisor is picked up only at terminal count: no runt interval
      if (preTick)
        divCnt <= (divCnt == '0) ? ctl.divisor : divCnt - 1'b1;
      if (osEvent)
        osCnt <= (osCnt == OS_W'(OVERSAMPLE - 1)) ? '0 : osCnt + 1'b1;
      if (rxActive || !toEnable)
        idleCnt <= '0;
      else if (bitEvent)
        idleCnt <= atLimit ? '0 : idleCnt + 1'b1;
      tick16    <= osEvent;
      tickBit   <= bitEvent;
      rxTimeout <= toHit;
    end
  end
endmodule

// File: rtl/sir_baud_gen.sv
module sir_baud_gen
  import sbg_pkg::*;
#(
  parameter int PRESCALE      = 26,
  parameter int OVERSAMPLE    = 16,
  parameter int DEFAULT_COUNT = 11,
  parameter int TO_BASE       = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        slowMode,
  input  logic        wrEn,
  input  logic        wrAddr,
  input  logic [15:0] wrData,
  input  logic        rxActive,
  output logic        tick16,
  output logic        tickBit,
  output logic        rxTimeout
);
  sbgCtl_t ctl;
  logic    toHit;

  sbg_ctrl #(.DEFAULT_COUNT(DEFAULT_COUNT)) uCtrl (
    .clk(clk), .rstN(rstN), .slowMode(slowMode), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .toHit(toHit), .ctl(ctl)
  );

  sbg_datapath #(
    .PRESCALE(PRESCALE), .OVERSAMPLE(OVERSAMPLE), .TO_BASE(TO_BASE)
  ) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rxActive(rxActive),
    .toHit(toHit), .tick16(tick16), .tickBit(tickBit), .rxTimeout(rxTimeout)
  );
endmodule

// File: rtl/sbg_checker.sv
module sbg_checker
  import sbg_pkg::*;
#(
  parameter int DEFAULT_COUNT = 11
) (
  input logic    clk,
  input logic    rstN,
  input logic    slowMode,
  input logic    wrEn,
  input logic    wrAddr,
  input logic    rxActive,
  input logic    tick16,
  input logic    tickBit,
  input logic    rxTimeout,
  input sbgCtl_t ctl
);
  // R1: the oversampling tick is a single-cycle pulse
  a_r1_tick_single: assert property (@(posedge clk) disable iff (!rstN)
    tick16 |=> !tick16);

  // R5: a bit tick only ever coincides with an oversampling tick
  a_r5_bit_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    tickBit |-> tick16);

  // R7: a selector held at 3 never lets a timeout through
  a_r7_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.toSel == 2'd3 && $past(ctl.toSel) == 2'd3) |-> !rxTimeout);

  // R8: selector write outside slow mode stores zero
  a_r8_forced_zero: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr && !slowMode) |=> (ctl.toSel == '0));

  // R9: activity in the previous cycle rules out a timeout
  a_r9_activity_clears: assert property (@(posedge clk) disable iff (!rstN)
    $past(rxActive) |-> !rxTimeout);

  // R10: a timeout pulse comes with the default count restored
  a_r10_default_restore: assert property (@(posedge clk) disable iff (!rstN)
    rxTimeout |-> (ctl.divisor == CNT_W'(DEFAULT_COUNT)));
endmodule

bind sir_baud_gen sbg_checker #(.DEFAULT_COUNT(DEFAULT_COUNT)) uChk (
  .clk(clk), .rstN(rstN), .slowMode(slowMode), .wrEn(wrEn), .wrAddr(wrAddr),
  .rxActive(rxActive), .tick16(tick16), .tickBit(tickBit),
  .rxTimeout(rxTimeout), .ctl(ctl)
);

// File: tb/sir_baud_gen_test.sv
module sir_baud_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int PRE  = 4;
  localparam int OVS  = 16;
  localparam int DEFC = 11;
  localparam int TOB  = 2;

  logic clk = 1'b0, rstN = 1'b0, slowMode = 1'b1, wrEn = 1'b0, wrAddr = 1'b0;
  logic [15:0] wrData = '0;
  logic rxActive = 1'b1;
  logic tick16, tickBit, rxTimeout;

  int checks = 0, errors = 0;
  bit finished = 0;
  int expGap[$];
  string expTag[$];
  int cyc = 0, lastTick = 0;
  bit haveLast = 0;

  sir_baud_gen #(.PRESCALE(PRE), .OVERSAMPLE(OVS), .DEFAULT_COUNT(DEFC),
                 .TO_BASE(TOB)) uut (
    .clk(clk), .rstN(rstN), .slowMode(slowMode), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rxActive(rxActive), .tick16(tick16), .tickBit(tickBit),
    .rxTimeout(rxTimeout));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Monitor: pops one expected gap per observed oversampling tick
  always @(negedge clk) begin
    cyc++;
    if (rstN && tick16) begin
      if (haveLast && expGap.size() > 0) begin
        int e;
        string t;
        e = expGap.pop_front();
        t = expTag.pop_front();
        check(cyc - lastTick == e, t, cyc - lastTick, e);
      end
      lastTick = cyc;
      haveLast = 1;
    end
  end

  task automatic push(input int gap, input string tag);
    expGap.push_back(gap);
    expTag.push_back(tag);
  endtask

  task automatic syncTick();
    do @(negedge clk); while (!tick16);
    @(negedge clk);
  endtask

  task automatic drain();
    while (expGap.size() != 0) @(negedge clk);
  endtask

  task automatic writeReg(input logic a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic bitGap(output int gap);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!tickBit);
  endtask

  // Drop activity just after a bit tick and count bit ticks to the timeout
  task automatic idleRun(input int limitTicks, output int nBits, output int nTo);
    nBits = 0; nTo = 0;
    do @(negedge clk); while (!tickBit);
    rxActive = 1'b0;
    while (nBits < limitTicks) begin
      @(negedge clk);
      if (tickBit) nBits++;
      if (rxTimeout) begin nTo++; break; end
    end
    rxActive = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int g, n, t;
    repeat (5) @(negedge clk);
    // R3: outputs low in reset
    check(!tick16 && !tickBit && !rxTimeout, "R3 reset outputs", {tick16, tickBit, rxTimeout}, 0);
    rstN = 1'b1;

    // R3/R1: default count gives PRE*(11+1)=48
    syncTick();
    repeat (3) push(PRE*(DEFC+1), "R3 default rate");
    drain();

    // R4/R2: in-progress interval keeps old length; upper bits ignored (0xFFC0 -> 0)
    syncTick();
    push(PRE*(DEFC+1), "R4 old interval completes");
    repeat (3) push(PRE*1, "R2 count 0 with upper bits set");
    writeReg(1'b0, 16'hFFC0);
    drain();

    writeReg(1'b0, 16'hA545); // count 5
    syncTick(); syncTick();
    repeat (3) push(PRE*6, "R1 count 5");
    drain();

    // R4: change 5 -> 2 mid-interval
    syncTick();
    push(PRE*6, "R4 no runt tick");
    repeat (3) push(PRE*3, "R1 count 2");
    repeat (8) @(negedge clk);
    writeReg(1'b0, 16'h0002);
    drain();

    // R5: bit tick spacing and coincidence
    bitGap(g);
    check(tick16 == 1'b1, "R5 bit tick with 16x tick", tick16, 1);
    bitGap(g);
    check(g == OVS*PRE*3, "R5 bit period", g, OVS*PRE*3);
    bitGap(g);
    check(g == OVS*PRE*3, "R5 bit period repeat", g, OVS*PRE*3);

    // R3: timeout off after reset even with an idle line
    idleRun(6, n, t);
    check(t == 0, "R3 timeout off after reset", t, 0);

    // R6: selector 0 -> TOB ticks, selector 1 -> 2*TOB, selector 2 -> 4*TOB
    writeReg(1'b0, 16'h0000);
    writeReg(1'b1, 16'h0000);
    idleRun(40, n, t);
    check(t == 1 && n == TOB, "R6 selector 0 interval", n, TOB);

    // R10: after the timeout the rate returns to the default
    syncTick();
    repeat (2) push(PRE*(DEFC+1), "R10 default count restored");
    drain();

    writeReg(1'b0, 16'h0000);
    writeReg(1'b1, 16'hF1FF); // selector 1, other bits ignored
    idleRun(40, n, t);
    check(t == 1 && n == 2*TOB, "R6 selector 1 interval", n, 2*TOB);

    writeReg(1'b0, 16'h0000);
    writeReg(1'b1, 16'h0200);
    idleRun(40, n, t);
    check(t == 1 && n == 4*TOB, "R6 selector 2 interval", n, 4*TOB);

    // R7: selector 3 disables
    writeReg(1'b0, 16'h0000);
    writeReg(1'b1, 16'h0300);
    idleRun(12, n, t);
    check(t == 0 && n == 12, "R7 selector 3 never times out", t, 0);

    // R9: activity in the middle restarts the idle count
    writeReg(1'b1, 16'h0000);
    do @(negedge clk); while (!tickBit);
    rxActive = 1'b0;
    n = 0; t = 0;
    do @(negedge clk); while (!tickBit);
    n++;
    rxActive = 1'b1;
    repeat (3) @(negedge clk);
    rxActive = 1'b0;
    while (n < 40 && t == 0) begin
      @(negedge clk);
      if (tickBit) n++;
      if (rxTimeout) t++;
    end
    rxActive = 1'b1;
    check(t == 1 && n == TOB + 1, "R9 activity clears idle count", n, TOB + 1);

    // R8: selector write outside slow mode stores 0
    writeReg(1'b0, 16'h0000);
    slowMode = 1'b0;
    writeReg(1'b1, 16'h0300);
    slowMode = 1'b1;
    idleRun(40, n, t);
    check(t == 1 && n == TOB, "R8 selector forced to 0", n, TOB);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule